// File: doc/BRIEF.md
# Low-Power Wake-Up Sequencer

This block brings a processor core back from a sleep or idle low-power state to full-speed operation. Software first moves the core into a low-power state, choosing sleep, primary-clock idle or fallback-clock idle. A later wake request, either an interrupt or a reset, starts the wake sequence. The sequencer then times the settling interval that suits the selected primary clock type. It raises the ready flag that belongs to that clock type and returns the core to the primary clock.

While the primary clock settles, the sequencer decides how the core and peripheral clocks behave. In the simplest case they stay gated. Otherwise they run from a fallback clock, and a one-cycle switch strobe marks the moment the clock select moves to the primary clock. Every interval is a cycle counter that advances on a reference tick. A mandatory short interval always runs side by side with the source-specific interval, so the longer of the two decides the total delay.

Top module: `lp_wake_seq`

## Requirements
- R1: After reset the block is asleep. cpu_clk_en, per_clk_en, clk_sel_pri, clk_switch, osc_rdy, intosc_stable and seq_done are all 0.
- R2: On a sleep wake with clk_src=0 (crystal), seq_done rises after OST_TICKS ticks, and osc_rdy rises with it. intosc_stable stays 0.
- R3: With clk_src=1 (crystal with PLL), the wake delay is OST_TICKS+PLL_TICKS ticks, and osc_rdy rises at the end of it.
- R4: With clk_src=2 (external or RC clock), the wake delay is SHORT_TICKS ticks, and neither ready flag is ever set.
- R5: With clk_src=3 (internal oscillator), the core is clocked from the primary clock after SHORT_TICKS ticks. intosc_stable and seq_done rise only after INTOSC_TICKS ticks, and osc_rdy stays 0.
- R6: The short interval runs at the same time as the source interval. The total delay is the larger of the two, never their sum.
- R7: In sleep (lp_mode=0) with two_speed_en=0, cpu_clk_en and per_clk_en stay 0 until the sequence completes.
- R8: In sleep with two_speed_en=1, or in fallback-clock idle (lp_mode=2 or 3), the core runs on the fallback clock (clk_sel_pri=0, cpu_clk_en=1) during the wait. The peripherals are clocked in both idle modes while the block is idle.
- R9: In primary-clock idle (lp_mode=1), only SHORT_TICKS ticks elapse before execution resumes, whatever the source. clk_sel_pri stays 1.
- R10: clk_switch is a one-cycle pulse. It is raised exactly when clk_sel_pri goes from 0 to 1 while the core was running on the fallback clock, and never when the core was gated.
- R11: wake_rst during the wait clears the counters and restarts the delay from zero. wake_irq during the wait has no effect.
- R12: The counters advance only in cycles where tick is 1.
- R13: The outputs change one clock after the tick that completes the relevant interval. All outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Reference tick that advances the interval counters |
| wake_irq | input | 1 | Wake request from an interrupt |
| wake_rst | input | 1 | Wake request from a reset; restarts a running wait |
| enter_lp | input | 1 | Enter the low-power state given by lp_mode (accepted when running) |
| lp_mode | input | 2 | 0 sleep, 1 primary-clock idle, 2/3 fallback-clock idle |
| clk_src | input | 2 | Primary clock type: 0 crystal, 1 crystal+PLL, 2 external/RC, 3 internal oscillator |
| two_speed_en | input | 1 | Run from the fallback clock during a sleep wake |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clk_sel_pri | output | 1 | 1 selects the primary clock, 0 the fallback clock |
| clk_switch | output | 1 | One-cycle strobe on the fallback-to-primary switch |
| osc_rdy | output | 1 | Crystal-type primary clock ready |
| intosc_stable | output | 1 | Internal oscillator stable |
| seq_done | output | 1 | Wake sequence complete, core on the primary clock |

## Verification
Each of the four clock types is woken from sleep. The measured delay separates the crystal, PLL, short-only and internal-oscillator intervals, and the flags show which ready indication belongs to each type. The same sources are woken from both idle modes and from sleep with the fallback clock enabled, which separates a gated wait from a fallback wait and shows when the switch strobe may appear. Mid-wait interrupt and reset pulses show that only a reset restarts the count. A stretch with the tick held low shows that counting follows the tick and not the clock.

// File: rtl/lp_wake_pkg.sv
// Shared codes and state type for the low-power wake sequencer.
// Assumes: 2-bit mode and clock-source encodings as listed below.
package lp_wake_pkg;
    typedef enum logic [1:0] {
        ST_LP   = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    localparam logic [1:0] MODE_SLEEP    = 2'd0;
    localparam logic [1:0] MODE_PRI_IDLE = 2'd1;

    localparam logic [1:0] SRC_XTAL      = 2'd0;
    localparam logic [1:0] SRC_XTAL_PLL  = 2'd1;
    localparam logic [1:0] SRC_EXT       = 2'd2;
    localparam logic [1:0] SRC_INTOSC    = 2'd3;
endpackage

// File: rtl/lp_wake_counter.sv
// Saturating interval counter advanced by a reference tick.
// Assumes: clear has priority; done is high once the count reaches target
// (immediately when target is zero).
module lp_wake_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Count ticks while running, stop at the target.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run && tick && (cnt_q < target)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Interval complete.
    always_comb done = (cnt_q >= target);
endmodule

// File: rtl/lp_wake_target.sv
// Picks the tick targets of the short and source-specific intervals.
// Assumes: primary-clock idle needs only the short interval.
module lp_wake_target #(
    parameter int W            = 6,
    parameter int SHORT_TICKS  = 4,
    parameter int OST_TICKS    = 10,
    parameter int PLL_TICKS    = 6,
    parameter int INTOSC_TICKS = 7
) (
    input  logic [1:0]   src,
    input  logic [1:0]   mode,
    output logic [W-1:0] short_tgt,
    output logic [W-1:0] long_tgt
);
    import lp_wake_pkg::*;

    // Short interval is fixed; the long one follows the clock type.
    always_comb begin
        short_tgt = W'(SHORT_TICKS);
        if (mode == MODE_PRI_IDLE) begin
            long_tgt = '0;
        end else begin
            case (src)
                SRC_XTAL:     long_tgt = W'(OST_TICKS);
                SRC_XTAL_PLL: long_tgt = W'(OST_TICKS + PLL_TICKS);
                SRC_INTOSC:   long_tgt = W'(INTOSC_TICKS);
                default:      long_tgt = '0;
            endcase
        end
    end
endmodule

// File: rtl/lp_wake_seq.sv
// Low-power wake sequencer top. Enters a low-power state on enter_lp and
// leaves it on a wake request. It times the short and source intervals in
// parallel, gates or falls back the core clock meanwhile, then switches
// to the primary clock and raises the matching ready flag.
// Assumes: single clock, synchronous active-low reset, inputs synchronous.
module lp_wake_seq #(
    parameter int SHORT_TICKS  = 4,
    parameter int OST_TICKS    = 10,
    parameter int PLL_TICKS    = 6,
    parameter int INTOSC_TICKS = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wake_irq,
    input  logic       wake_rst,
    input  logic       enter_lp,
    input  logic [1:0] lp_mode,
    input  logic [1:0] clk_src,
    input  logic       two_speed_en,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       clk_sel_pri,
    output logic       clk_switch,
    output logic       osc_rdy,
    output logic       intosc_stable,
    output logic       seq_done
);
    import lp_wake_pkg::*;

    localparam int SUM_TICKS = SHORT_TICKS + OST_TICKS + PLL_TICKS + INTOSC_TICKS;
    localparam int CW        = $clog2(SUM_TICKS + 1);
    localparam int NCNT      = 2;

    seq_state_t   st_q;
    logic [1:0]   mode_q;
    logic [1:0]   src_q;
    logic         ts_q;
    logic [CW-1:0] tgt [NCNT];
    logic [NCNT-1:0] cnt_done;
    logic         start_wait;
    logic         fb_start;
    logic         fb_wait;
    logic         prim_ok;
    logic         all_done;
    logic         n_cpu;
    logic         n_sel;

    lp_wake_target #(
        .W(CW), .SHORT_TICKS(SHORT_TICKS), .OST_TICKS(OST_TICKS),
        .PLL_TICKS(PLL_TICKS), .INTOSC_TICKS(INTOSC_TICKS)
    ) u_tgt (
        .src(src_q), .mode(mode_q), .short_tgt(tgt[0]), .long_tgt(tgt[1])
    );

    // Index 0 is the short interval, index 1 the source interval.
    for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
        lp_wake_counter #(.W(CW)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clear(start_wait),
            .run(st_q == ST_WAIT), .tick(tick),
            .target(tgt[gi]), .done(cnt_done[gi])
        );
    end

    // Wake decode, fallback policy and next clock controls.
    always_comb begin
        start_wait = ((st_q == ST_LP) && (wake_irq || wake_rst)) ||
                     ((st_q == ST_WAIT) && wake_rst);
        fb_start   = (mode_q[1]) || ((mode_q == MODE_SLEEP) && two_speed_en);
        fb_wait    = (mode_q[1]) || ((mode_q == MODE_SLEEP) && ts_q);
        all_done   = &cnt_done;
        prim_ok    = ((src_q == SRC_INTOSC) && (mode_q != MODE_PRI_IDLE))
                     ? cnt_done[0] : all_done;
        n_sel      = prim_ok || (mode_q == MODE_PRI_IDLE);
        n_cpu      = prim_ok || fb_wait;
    end

    // Sequencer state and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= ST_LP;
            mode_q        <= MODE_SLEEP;
            src_q         <= SRC_XTAL;
            ts_q          <= 1'b0;
            cpu_clk_en    <= 1'b0;
            per_clk_en    <= 1'b0;
            clk_sel_pri   <= 1'b0;
            clk_switch    <= 1'b0;
            osc_rdy       <= 1'b0;
            intosc_stable <= 1'b0;
            seq_done      <= 1'b0;
        end else begin
            clk_switch <= 1'b0;
            if (start_wait) begin
                st_q          <= ST_WAIT;
                src_q         <= clk_src;
                ts_q          <= two_speed_en;
                cpu_clk_en    <= fb_start;
                per_clk_en    <= fb_start || (mode_q != MODE_SLEEP);
                clk_sel_pri   <= (mode_q == MODE_PRI_IDLE);
                osc_rdy       <= 1'b0;
                intosc_stable <= 1'b0;
                seq_done      <= 1'b0;
            end else if (st_q == ST_WAIT) begin
                cpu_clk_en  <= n_cpu;
                per_clk_en  <= n_cpu || (mode_q != MODE_SLEEP);
                clk_sel_pri <= n_sel;
                clk_switch  <= n_sel && !clk_sel_pri && cpu_clk_en;
                if (all_done) begin
                    st_q          <= ST_RUN;
                    seq_done      <= 1'b1;
                    osc_rdy       <= (src_q == SRC_XTAL) || (src_q == SRC_XTAL_PLL);
                    intosc_stable <= (src_q == SRC_INTOSC);
                end
            end else if ((st_q == ST_RUN) && enter_lp) begin
                st_q          <= ST_LP;
                mode_q        <= lp_mode;
                cpu_clk_en    <= 1'b0;
                per_clk_en    <= (lp_mode != MODE_SLEEP);
                clk_sel_pri   <= (lp_mode == MODE_PRI_IDLE);
                osc_rdy       <= 1'b0;
                intosc_stable <= 1'b0;
                seq_done      <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lp_wake_chk.sv
// Port-level property checker for lp_wake_seq, attached by bind.
// Assumes: synchronous active-low reset held for at least one clock.
module lp_wake_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_clk_en,
    input logic clk_sel_pri,
    input logic clk_switch,
    input logic osc_rdy,
    input logic intosc_stable,
    input logic seq_done
);
    // R10: strobe lasts one cycle.
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_switch |=> !clk_switch);

    // R10: strobe only on a 0-to-1 select change with the core clocked.
    p_strobe_at_switch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clk_switch |-> (clk_sel_pri && cpu_clk_en && !$past(clk_sel_pri)));

    // R13: completion means the core runs on the primary clock.
    p_done_on_primary_r13: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (cpu_clk_en && clk_sel_pri));

    // R2: a ready flag is only shown once the sequence is complete.
    p_flag_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_rdy || intosc_stable) |-> seq_done);

    // R4: the two ready flags never appear together.
    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_rdy && intosc_stable));
endmodule

bind lp_wake_seq lp_wake_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_clk_en(cpu_clk_en),
    .clk_sel_pri(clk_sel_pri), .clk_switch(clk_switch),
    .osc_rdy(osc_rdy), .intosc_stable(intosc_stable), .seq_done(seq_done)
);

// File: tb/sim_lp_wake_seq.sv
// Directed bench for lp_wake_seq: one task per scenario.
// Counts c are negedges after the drive negedge; a delay of n ticks
// (tick always 1) shows an output first at c = n + 2.
module sim_lp_wake_seq;
    localparam int SHORT  = 4;
    localparam int OST    = 10;
    localparam int PLL    = 6;
    localparam int INTOSC = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic wake_irq = 1'b0;
    logic wake_rst = 1'b0;
    logic enter_lp = 1'b0;
    logic [1:0] lp_mode = 2'd0;
    logic [1:0] clk_src = 2'd0;
    logic two_speed_en = 1'b0;
    logic cpu_clk_en, per_clk_en, clk_sel_pri, clk_switch;
    logic osc_rdy, intosc_stable, seq_done;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    lp_wake_seq #(.SHORT_TICKS(SHORT), .OST_TICKS(OST), .PLL_TICKS(PLL),
                  .INTOSC_TICKS(INTOSC)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wake_irq(wake_irq),
        .wake_rst(wake_rst), .enter_lp(enter_lp), .lp_mode(lp_mode),
        .clk_src(clk_src), .two_speed_en(two_speed_en),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .clk_sel_pri(clk_sel_pri), .clk_switch(clk_switch),
        .osc_rdy(osc_rdy), .intosc_stable(intosc_stable), .seq_done(seq_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wake and record when each output first rises; stop 2 cycles after done.
    task automatic wake_measure(input logic [1:0] src, input bit use_rst,
                                output int c_done, output int c_cpu,
                                output int c_sel, output int c_str,
                                output int n_str, output int gated_before);
        int c = 0;
        int post = -1;
        c_done = -1; c_cpu = -1; c_sel = -1; c_str = -1; n_str = 0;
        gated_before = 1;
        @(negedge clk);
        clk_src = src; wake_irq = !use_rst; wake_rst = use_rst;
        @(negedge clk);
        wake_irq = 1'b0; wake_rst = 1'b0;
        while (c < 60 && post != 0) begin
            c++;
            if (cpu_clk_en && c_cpu < 0) c_cpu = c;
            if (clk_sel_pri && c_sel < 0) c_sel = c;
            if (clk_switch) begin n_str++; if (c_str < 0) c_str = c; end
            if (!seq_done && (cpu_clk_en || per_clk_en)) gated_before = 0;
            if (seq_done && c_done < 0) begin c_done = c; post = 2; end
            else if (post > 0) post--;
            if (post != 0) @(negedge clk);
        end
    endtask

    task automatic go_lp(input logic [1:0] mode, input bit ts);
        @(negedge clk);
        lp_mode = mode; two_speed_en = ts; enter_lp = 1'b1;
        @(negedge clk);
        enter_lp = 1'b0;
    endtask

    task automatic t_reset;
        chk(!cpu_clk_en && !per_clk_en && !clk_sel_pri && !clk_switch,
            "R1 clocks after reset", {cpu_clk_en, per_clk_en, clk_sel_pri}, 0);
        chk(!osc_rdy && !intosc_stable && !seq_done, "R1 flags after reset",
            {osc_rdy, intosc_stable, seq_done}, 0);
    endtask

    task automatic t_crystal;
        int d, cc, cs, cst, ns, g;
        wake_measure(2'd0, 1'b0, d, cc, cs, cst, ns, g);
        chk(d == OST + 2, "R2 R6 crystal delay", d, OST + 2);
        chk(osc_rdy && !intosc_stable, "R2 crystal flags", {osc_rdy, intosc_stable}, 2);
        chk(g == 1 && cc == d, "R7 core gated in sleep", cc, d);
        chk(ns == 0, "R10 no strobe when gated", ns, 0);
    endtask

    task automatic t_pll;
        int d, cc, cs, cst, ns, g;
        go_lp(2'd0, 1'b1);
        wake_measure(2'd1, 1'b0, d, cc, cs, cst, ns, g);
        chk(d == OST + PLL + 2, "R3 pll delay", d, OST + PLL + 2);
        chk(osc_rdy, "R3 pll ready flag", osc_rdy, 1);
        chk(cc == 1 && cs == d, "R8 fallback during two-speed wake", cs, d);
        chk(ns == 1 && cst == d, "R10 single strobe at switch", cst, d);
    endtask

    task automatic t_ext;
        int d, cc, cs, cst, ns, g;
        go_lp(2'd0, 1'b0);
        wake_measure(2'd2, 1'b0, d, cc, cs, cst, ns, g);
        chk(d == SHORT + 2, "R4 R6 external delay", d, SHORT + 2);
        chk(!osc_rdy && !intosc_stable, "R4 no flags", {osc_rdy, intosc_stable}, 0);
    endtask

    task automatic t_intosc;
        int d, cc, cs, cst, ns, g;
        go_lp(2'd0, 1'b0);
        wake_measure(2'd3, 1'b0, d, cc, cs, cst, ns, g);
        chk(cc == SHORT + 2 && cs == SHORT + 2, "R5 core runs early", cc, SHORT + 2);
        chk(d == INTOSC + 2, "R5 stable delay", d, INTOSC + 2);
        chk(intosc_stable && !osc_rdy, "R5 flags", {osc_rdy, intosc_stable}, 1);
    endtask

    task automatic t_sec_idle;
        int d, cc, cs, cst, ns, g;
        go_lp(2'd2, 1'b0);
        @(negedge clk);
        chk(per_clk_en && !cpu_clk_en, "R8 peripherals clocked in idle",
            {per_clk_en, cpu_clk_en}, 2);
        wake_measure(2'd0, 1'b0, d, cc, cs, cst, ns, g);
        chk(cc == 1 && d == OST + 2, "R8 fallback idle wake", d, OST + 2);
        chk(ns == 1 && cst == d, "R10 strobe from fallback idle", cst, d);
    endtask

    task automatic t_pri_idle;
        int d, cc, cs, cst, ns, g;
        go_lp(2'd1, 1'b0);
        wake_measure(2'd1, 1'b0, d, cc, cs, cst, ns, g);
        chk(d == SHORT + 2 && cc == d, "R9 short delay only", d, SHORT + 2);
        chk(cs == 1 && ns == 0, "R9 primary kept selected", ns, 0);
    endtask

    task automatic t_restart;
        int c = 0;
        go_lp(2'd0, 1'b0);
        @(negedge clk);
        clk_src = 2'd0; wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
        repeat (4) @(negedge clk);
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
        c = 6;
        while (!seq_done && c < 60) begin @(negedge clk); c++; end
        chk(c == OST + 2, "R11 irq in wait ignored", c, OST + 2);
        go_lp(2'd0, 1'b0);
        @(negedge clk);
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
        repeat (5) @(negedge clk);
        wake_rst = 1'b1;
        @(negedge clk);
        wake_rst = 1'b0;
        c = 1;
        while (!seq_done && c < 60) begin @(negedge clk); c++; end
        chk(c == OST + 2, "R11 reset restarts count", c, OST + 2);
    endtask

    task automatic t_tick;
        int c = 0;
        go_lp(2'd0, 1'b0);
        @(negedge clk);
        clk_src = 2'd2; tick = 1'b0; wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
        repeat (12) @(negedge clk);
        chk(!seq_done, "R12 no progress without tick", seq_done, 0);
        tick = 1'b1;
        @(negedge clk);
        c = 1;
        while (!seq_done && c < 60) begin @(negedge clk); c++; end
        chk(c == SHORT + 1, "R12 R13 counts resume on tick", c, SHORT + 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_crystal();
        t_pll();
        t_ext();
        t_intosc();
        t_sec_idle();
        t_pri_idle();
        t_restart();
        t_tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule